// File: doc/BRIEF.md
# Single-Cycle Instruction Decoder

This block turns one 32-bit instruction word of a classic 32-bit load/store architecture into the control word that steers a single-cycle core's datapath for that same cycle. It is purely combinational: the instruction fetched at the current PC goes in, and the operation code for the ALU, the operand routing, the immediate extension mode, the register-file and memory write strobes, the write-back choice and the next-PC choice come out before the clock edge that commits the instruction.

A zero primary opcode hands decoding to the function field in the low six bits. Every other opcode is decoded on its own. The standard encodings of the 32-bit classic integer set are used for the register arithmetic and logic group, the shifts, the set-on-less-than forms, the immediate forms, load word, store word, the two equality branches, the absolute jumps and the register jump. The datapath that acts on these controls is outside this block. Any opcode or function code that is not listed decodes to an all-zero control word, so such an instruction changes no state and simply falls through to PC+4.

Top module: `scDecoder`

## Requirements
- R1: With opcode 0, function codes 0x20 to 0x27 (add, addu, sub, subu, and, or, xor, nor) give aluOp 0 to 7 in that order. They also give aSel 0 (Rs), bSel 0 (Rt), dstSel 0 (rd), wbSel 0 (ALU), extSigned 0, memWrite 0, pcSel 0 (PC+4) and regWrite 1.
- R2: With opcode 0, function codes 0x00, 0x02 and 0x03 (shift left logical, shift right logical and shift right arithmetic by immediate) give aluOp 10, 11 and 12. They also give aSel 1 (instruction bits [10:6], zero-extended), bSel 0 (Rt), dstSel 0 and regWrite 1.
- R3: With opcode 0, function codes 0x04, 0x06 and 0x07 (variable shifts) give aluOp 10, 11 and 12. They also give aSel 2 (Rs[4:0], zero-extended), bSel 0, dstSel 0 and regWrite 1.
- R4: The signed compare forms give aluOp 8 and the unsigned forms give aluOp 9. These are function 0x2A and 0x2B, and opcodes 0x0A and 0x0B. All four give wbSel 2, which selects the comparison bit widened to a word.
- R5: The immediate forms set bSel 1 (extended immediate), aSel 0 and dstSel 1 (rt). The immediate is sign-extended (extSigned 1) for opcodes 0x08, 0x09, 0x0A, 0x0B, 0x23 and 0x2B. It is zero-extended for 0x0C, 0x0D, 0x0E and 0x0F. Opcodes 0x08, 0x09, 0x0C, 0x0D and 0x0E give aluOp 0, 1, 4, 5 and 6.
- R6: Opcode 0x0F (load upper) gives aluOp 13, bSel 1, extSigned 0, wbSel 0 and dstSel 1.
- R7: Opcode 0x23 (load word) gives aluOp 1, bSel 1, extSigned 1, wbSel 1 (memory data), dstSel 1 and memWrite 0.
- R8: Opcode 0x2B (store word) gives aluOp 1, bSel 1, extSigned 1 and memWrite 1. It gives regWrite 0 whatever the rt index is.
- R9: Opcodes 0x04 and 0x05 (branch if equal, branch if not equal) give aluOp 3, aSel 0, bSel 0, extSigned 1 and regWrite 0. They give pcSel 1 and pcSel 2 respectively.
- R10: Opcode 0x02 (jump) gives pcSel 3, and function 0x08 under opcode 0 (register jump) gives pcSel 4. Both give regWrite 0 and all other fields 0. Opcode 0x03 (jump and link) gives pcSel 3, regWrite 1, dstSel 2 (register 31) and wbSel 3 (link value).
- R11: regWrite is 0 when the selected destination index (rd for dstSel 0, rt for dstSel 1) is zero. All other control fields keep their decoded values.
- R12: An unlisted opcode, or an unlisted function code under opcode 0, gives every output 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word being executed this cycle |
| aluOp | output | 4 | ALU operation: 0 add, 1 addu, 2 sub, 3 subu, 4 and, 5 or, 6 xor, 7 nor, 8 slt, 9 sltu, 10 sll, 11 srl, 12 sra, 13 lui |
| aSel | output | 2 | ALU A source: 0 Rs, 1 shift amount field, 2 Rs[4:0] |
| bSel | output | 1 | ALU B source: 0 Rt, 1 extended immediate |
| extSigned | output | 1 | Immediate extension: 1 sign, 0 zero |
| regWrite | output | 1 | Register file write enable |
| dstSel | output | 2 | Destination: 0 rd, 1 rt, 2 register 31 |
| wbSel | output | 2 | Write-back source: 0 ALU, 1 memory, 2 compare bit, 3 link value |
| memWrite | output | 1 | Data memory write enable |
| pcSel | output | 3 | Next PC: 0 PC+4, 1 branch if zero, 2 branch if not zero, 3 jump target, 4 Rs |

## Verification
Every listed instruction is first applied once with non-zero register fields. This checks each opcode and function code against its own complete control word, so a swapped ALU code or a wrong operand route shows up on exactly one instruction. The same instructions are then applied with a zero destination field, which separates the write suppression from the rest of the decode. Store word with rt zero shows that the suppression does not touch the memory strobe. Unlisted opcodes and function codes close the directed set. A long run of random words then mixes listed opcodes with arbitrary field contents, so that bits outside the opcode, function and destination fields are shown not to disturb the decode.

// File: rtl/scDecPkg.sv
package scDecPkg;

  localparam int INSTR_W = 32;
  localparam int FIELD_W = 6;
  localparam int REG_IDX_W = 5;
  localparam int LINK_REG = 31;
  localparam int OPC_LSB = INSTR_W - FIELD_W;
  localparam int RS_LSB = OPC_LSB - REG_IDX_W;
  localparam int RT_LSB = RS_LSB - REG_IDX_W;
  localparam int RD_LSB = RT_LSB - REG_IDX_W;

  typedef enum logic [3:0] {
    ALU_ADD = 4'd0, ALU_ADDU = 4'd1, ALU_SUB = 4'd2, ALU_SUBU = 4'd3,
    ALU_AND = 4'd4, ALU_OR = 4'd5, ALU_XOR = 4'd6, ALU_NOR = 4'd7,
    ALU_SLT = 4'd8, ALU_SLTU = 4'd9, ALU_SLL = 4'd10, ALU_SRL = 4'd11,
    ALU_SRA = 4'd12, ALU_LUI = 4'd13
  } aluOp_e;

  typedef enum logic [1:0] {A_RS = 2'd0, A_SHAMT = 2'd1, A_RSLOW = 2'd2} aSel_e;
  typedef enum logic [1:0] {DST_RD = 2'd0, DST_RT = 2'd1, DST_RA = 2'd2} dstSel_e;
  typedef enum logic [1:0] {WB_ALU = 2'd0, WB_MEM = 2'd1, WB_CMP = 2'd2, WB_LINK = 2'd3} wbSel_e;
  typedef enum logic [2:0] {
    PC_SEQ = 3'd0, PC_BEQ = 3'd1, PC_BNE = 3'd2, PC_JUMP = 3'd3, PC_REG = 3'd4
  } pcSel_e;

  // primary opcodes
  localparam logic [FIELD_W-1:0] OP_SPECIAL = 6'h00, OP_J = 6'h02, OP_JAL = 6'h03;
  localparam logic [FIELD_W-1:0] OP_BEQ = 6'h04, OP_BNE = 6'h05;
  localparam logic [FIELD_W-1:0] OP_ADDI = 6'h08, OP_ADDIU = 6'h09, OP_SLTI = 6'h0A;
  localparam logic [FIELD_W-1:0] OP_SLTIU = 6'h0B, OP_ANDI = 6'h0C, OP_ORI = 6'h0D;
  localparam logic [FIELD_W-1:0] OP_XORI = 6'h0E, OP_LUI = 6'h0F;
  localparam logic [FIELD_W-1:0] OP_LW = 6'h23, OP_SW = 6'h2B;

  // function codes under OP_SPECIAL
  localparam logic [FIELD_W-1:0] FN_SLL = 6'h00, FN_SRL = 6'h02, FN_SRA = 6'h03;
  localparam logic [FIELD_W-1:0] FN_SLLV = 6'h04, FN_SRLV = 6'h06, FN_SRAV = 6'h07;
  localparam logic [FIELD_W-1:0] FN_JR = 6'h08;
  localparam logic [FIELD_W-1:0] FN_ADD = 6'h20, FN_ADDU = 6'h21, FN_SUB = 6'h22;
  localparam logic [FIELD_W-1:0] FN_SUBU = 6'h23, FN_AND = 6'h24, FN_OR = 6'h25;
  localparam logic [FIELD_W-1:0] FN_XOR = 6'h26, FN_NOR = 6'h27;
  localparam logic [FIELD_W-1:0] FN_SLT = 6'h2A, FN_SLTU = 6'h2B;

  // strobes from the field decoder to the control-word builder
  typedef struct packed {
    aluOp_e op;
    logic   useShamt;
    logic   useRsLow;
    logic   useImm;
    logic   signExt;
    logic   writesRd;
    logic   writesRt;
    logic   writesRa;
    logic   fromMem;
    logic   fromCmp;
    logic   memStore;
    logic   brEq;
    logic   brNe;
    logic   jmpAbs;
    logic   jmpReg;
  } decStrobes_t;

endpackage

// File: rtl/scDecFieldCtl.sv
module scDecFieldCtl
  import scDecPkg::*;
(
  input  logic [FIELD_W-1:0] opcode,
  input  logic [FIELD_W-1:0] funct,
  output decStrobes_t        strb
);

  always_comb begin
    strb = '0;
    case (opcode)
      OP_SPECIAL: begin
        case (funct)
          FN_SLL:  begin strb.op = ALU_SLL; strb.useShamt = 1'b1; strb.writesRd = 1'b1; end
          FN_SRL:  begin strb.op = ALU_SRL; strb.useShamt = 1'b1; strb.writesRd = 1'b1; end
          FN_SRA:  begin strb.op = ALU_SRA; strb.useShamt = 1'b1; strb.writesRd = 1'b1; end
          FN_SLLV: begin strb.op = ALU_SLL; strb.useRsLow = 1'b1; strb.writesRd = 1'b1; end
          FN_SRLV: begin strb.op = ALU_SRL; strb.useRsLow = 1'b1; strb.writesRd = 1'b1; end
          FN_SRAV: begin strb.op = ALU_SRA; strb.useRsLow = 1'b1; strb.writesRd = 1'b1; end
          FN_JR:   strb.jmpReg = 1'b1;
          FN_ADD:  begin strb.op = ALU_ADD;  strb.writesRd = 1'b1; end
          FN_ADDU: begin strb.op = ALU_ADDU; strb.writesRd = 1'b1; end
          FN_SUB:  begin strb.op = ALU_SUB;  strb.writesRd = 1'b1; end
          FN_SUBU: begin strb.op = ALU_SUBU; strb.writesRd = 1'b1; end
          FN_AND:  begin strb.op = ALU_AND;  strb.writesRd = 1'b1; end
          FN_OR:   begin strb.op = ALU_OR;   strb.writesRd = 1'b1; end
          FN_XOR:  begin strb.op = ALU_XOR;  strb.writesRd = 1'b1; end
          FN_NOR:  begin strb.op = ALU_NOR;  strb.writesRd = 1'b1; end
          FN_SLT:  begin strb.op = ALU_SLT;  strb.writesRd = 1'b1; strb.fromCmp = 1'b1; end
          FN_SLTU: begin strb.op = ALU_SLTU; strb.writesRd = 1'b1; strb.fromCmp = 1'b1; end
          default: strb = '0;
        endcase
      end
      OP_J:   strb.jmpAbs = 1'b1;
      OP_JAL: begin strb.jmpAbs = 1'b1; strb.writesRa = 1'b1; end
      OP_BEQ: begin strb.op = ALU_SUBU; strb.signExt = 1'b1; strb.brEq = 1'b1; end
      OP_BNE: begin strb.op = ALU_SUBU; strb.signExt = 1'b1; strb.brNe = 1'b1; end
      OP_ADDI, OP_ADDIU, OP_SLTI, OP_SLTIU: begin
        strb.useImm   = 1'b1;
        strb.signExt  = 1'b1;
        strb.writesRt = 1'b1;
        strb.fromCmp  = (opcode == OP_SLTI) || (opcode == OP_SLTIU);
        case (opcode)
          OP_ADDI:  strb.op = ALU_ADD;
          OP_ADDIU: strb.op = ALU_ADDU;
          OP_SLTI:  strb.op = ALU_SLT;
          default:  strb.op = ALU_SLTU;
        endcase
      end
      OP_ANDI, OP_ORI, OP_XORI, OP_LUI: begin
        strb.useImm   = 1'b1;
        strb.writesRt = 1'b1;
        case (opcode)
          OP_ANDI: strb.op = ALU_AND;
          OP_ORI:  strb.op = ALU_OR;
          OP_XORI: strb.op = ALU_XOR;
          default: strb.op = ALU_LUI;
        endcase
      end
      OP_LW: begin
        strb.op = ALU_ADDU; strb.useImm = 1'b1; strb.signExt = 1'b1;
        strb.writesRt = 1'b1; strb.fromMem = 1'b1;
      end
      OP_SW: begin
        strb.op = ALU_ADDU; strb.useImm = 1'b1; strb.signExt = 1'b1;
        strb.memStore = 1'b1;
      end
      default: strb = '0;
    endcase
  end

  // R12: at most one control-flow or store class per instruction
  always_comb begin
    a_r12_one_class: assert ($onehot0({strb.brEq, strb.brNe, strb.jmpAbs, strb.jmpReg, strb.memStore}))
      else $error("a_r12_one_class: several classes decoded");
    // R10: only jump-and-link names the link register
    a_r10_link_jump: assert (!strb.writesRa || strb.jmpAbs)
      else $error("a_r10_link_jump: link write without jump");
  end

endmodule

// File: rtl/scDecCtlWord.sv
module scDecCtlWord
  import scDecPkg::*;
(
  input  decStrobes_t          strb,
  input  logic [REG_IDX_W-1:0] rdIdx,
  input  logic [REG_IDX_W-1:0] rtIdx,
  output aluOp_e               aluOp,
  output aSel_e                aSel,
  output logic                 bSel,
  output logic                 extSigned,
  output logic                 regWrite,
  output dstSel_e              dstSel,
  output wbSel_e               wbSel,
  output logic                 memWrite,
  output pcSel_e               pcSel
);

  logic rdLive, rtLive;

  assign rdLive    = |rdIdx;
  assign rtLive    = |rtIdx;
  assign aluOp     = strb.op;
  assign bSel      = strb.useImm;
  assign extSigned = strb.signExt;
  assign memWrite  = strb.memStore;
  assign regWrite  = (strb.writesRd & rdLive) | (strb.writesRt & rtLive) | strb.writesRa;

  always_comb begin
    if (strb.useShamt)      aSel = A_SHAMT;
    else if (strb.useRsLow) aSel = A_RSLOW;
    else                    aSel = A_RS;

    if (strb.writesRa)      dstSel = DST_RA;
    else if (strb.writesRt) dstSel = DST_RT;
    else                    dstSel = DST_RD;

    if (strb.writesRa)      wbSel = WB_LINK;
    else if (strb.fromMem)  wbSel = WB_MEM;
    else if (strb.fromCmp)  wbSel = WB_CMP;
    else                    wbSel = WB_ALU;

    if (strb.brEq)          pcSel = PC_BEQ;
    else if (strb.brNe)     pcSel = PC_BNE;
    else if (strb.jmpAbs)   pcSel = PC_JUMP;
    else if (strb.jmpReg)   pcSel = PC_REG;
    else                    pcSel = PC_SEQ;
  end

  always_comb begin
    // R8: a store never writes the register file
    a_r8_store_no_regwrite: assert (!(memWrite && regWrite))
      else $error("a_r8_store_no_regwrite");
    // R9: conditional branches use subtract and write nothing
    a_r9_branch_subtract: assert (!(pcSel == PC_BEQ || pcSel == PC_BNE) || (aluOp == ALU_SUBU && !regWrite))
      else $error("a_r9_branch_subtract");
    // R11: a granted write never targets index zero
    a_r11_no_zero_dest: assert (!regWrite || dstSel == DST_RA
                                || (dstSel == DST_RD && rdIdx != '0) || (dstSel == DST_RT && rtIdx != '0))
      else $error("a_r11_no_zero_dest");
    // R7: memory write-back comes from a load, which is not a store
    a_r7_load_not_store: assert (!(wbSel == WB_MEM && memWrite))
      else $error("a_r7_load_not_store");
  end

endmodule

// File: rtl/scDecoder.sv
module scDecoder
  import scDecPkg::*;
(
  input  logic [31:0] instr,
  output logic [3:0]  aluOp,
  output logic [1:0]  aSel,
  output logic        bSel,
  output logic        extSigned,
  output logic        regWrite,
  output logic [1:0]  dstSel,
  output logic [1:0]  wbSel,
  output logic        memWrite,
  output logic [2:0]  pcSel
);

  decStrobes_t strb;
  aluOp_e      aluOpE;
  aSel_e       aSelE;
  dstSel_e     dstSelE;
  wbSel_e      wbSelE;
  pcSel_e      pcSelE;

  scDecFieldCtl u_fieldCtl (
    .opcode (instr[OPC_LSB +: FIELD_W]),
    .funct  (instr[FIELD_W-1:0]),
    .strb   (strb)
  );

  scDecCtlWord u_ctlWord (
    .strb      (strb),
    .rdIdx     (instr[RD_LSB +: REG_IDX_W]),
    .rtIdx     (instr[RT_LSB +: REG_IDX_W]),
    .aluOp     (aluOpE),
    .aSel      (aSelE),
    .bSel      (bSel),
    .extSigned (extSigned),
    .regWrite  (regWrite),
    .dstSel    (dstSelE),
    .wbSel     (wbSelE),
    .memWrite  (memWrite),
    .pcSel     (pcSelE)
  );

  assign aluOp  = aluOpE;
  assign aSel   = aSelE;
  assign dstSel = dstSelE;
  assign wbSel  = wbSelE;
  assign pcSel  = pcSelE;

endmodule

// File: tb/scDecoder_tb.sv
module scDecoder_tb;

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic [31:0] instr = '0;
  logic [3:0]  aluOp;
  logic [1:0]  aSel, dstSel, wbSel;
  logic        bSel, extSigned, regWrite, memWrite;
  logic [2:0]  pcSel;

  scDecoder u_dut (
    .instr(instr), .aluOp(aluOp), .aSel(aSel), .bSel(bSel), .extSigned(extSigned),
    .regWrite(regWrite), .dstSel(dstSel), .wbSel(wbSel), .memWrite(memWrite), .pcSel(pcSel)
  );

  typedef struct packed {
    logic [3:0] op; logic [1:0] a; logic b; logic e; logic w;
    logic [1:0] d; logic [1:0] wb; logic m; logic [2:0] pc;
  } ctl_t;

  ctl_t        expQ[$];
  string       tagQ[$];
  logic [31:0] insQ[$];
  int nRun = 0, nFail = 0;
  bit done = 1'b0;

  function automatic ctl_t mk(int op, int a, int b, int e, int w, int d, int wb, int m, int pc);
    ctl_t c;
    c.op = 4'(op); c.a = 2'(a); c.b = 1'(b); c.e = 1'(e); c.w = 1'(w);
    c.d = 2'(d); c.wb = 2'(wb); c.m = 1'(m); c.pc = 3'(pc);
    return c;
  endfunction

  function automatic logic [31:0] rIns(int rs, int rt, int rd, int sh, int fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'(sh), 6'(fn)};
  endfunction

  function automatic logic [31:0] iIns(int op, int rs, int rt, int imm);
    return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  // reference built from the requirement text, used for the random mix
  function automatic ctl_t model(logic [31:0] ins);
    logic [5:0] op = ins[31:26];
    logic [5:0] fn = ins[5:0];
    bit rdz = (ins[15:11] == 0);
    bit rtz = (ins[20:16] == 0);
    ctl_t c = '0;
    if (op == 6'h00) begin
      if (fn >= 6'h20 && fn <= 6'h27) c = mk(int'(fn) - 32, 0, 0, 0, !rdz, 0, 0, 0, 0);
      else if (fn == 6'h2A) c = mk(8, 0, 0, 0, !rdz, 0, 2, 0, 0);
      else if (fn == 6'h2B) c = mk(9, 0, 0, 0, !rdz, 0, 2, 0, 0);
      else if (fn == 6'h00) c = mk(10, 1, 0, 0, !rdz, 0, 0, 0, 0);
      else if (fn == 6'h02) c = mk(11, 1, 0, 0, !rdz, 0, 0, 0, 0);
      else if (fn == 6'h03) c = mk(12, 1, 0, 0, !rdz, 0, 0, 0, 0);
      else if (fn == 6'h04) c = mk(10, 2, 0, 0, !rdz, 0, 0, 0, 0);
      else if (fn == 6'h06) c = mk(11, 2, 0, 0, !rdz, 0, 0, 0, 0);
      else if (fn == 6'h07) c = mk(12, 2, 0, 0, !rdz, 0, 0, 0, 0);
      else if (fn == 6'h08) c = mk(0, 0, 0, 0, 0, 0, 0, 0, 4);
    end else begin
      case (op)
        6'h02: c = mk(0, 0, 0, 0, 0, 0, 0, 0, 3);
        6'h03: c = mk(0, 0, 0, 0, 1, 2, 3, 0, 3);
        6'h04: c = mk(3, 0, 0, 1, 0, 0, 0, 0, 1);
        6'h05: c = mk(3, 0, 0, 1, 0, 0, 0, 0, 2);
        6'h08: c = mk(0, 0, 1, 1, !rtz, 1, 0, 0, 0);
        6'h09: c = mk(1, 0, 1, 1, !rtz, 1, 0, 0, 0);
        6'h0A: c = mk(8, 0, 1, 1, !rtz, 1, 2, 0, 0);
        6'h0B: c = mk(9, 0, 1, 1, !rtz, 1, 2, 0, 0);
        6'h0C: c = mk(4, 0, 1, 0, !rtz, 1, 0, 0, 0);
        6'h0D: c = mk(5, 0, 1, 0, !rtz, 1, 0, 0, 0);
        6'h0E: c = mk(6, 0, 1, 0, !rtz, 1, 0, 0, 0);
        6'h0F: c = mk(13, 0, 1, 0, !rtz, 1, 0, 0, 0);
        6'h23: c = mk(1, 0, 1, 1, !rtz, 1, 1, 0, 0);
        6'h2B: c = mk(1, 0, 1, 1, 0, 0, 0, 1, 0);
        default: c = '0;
      endcase
    end
    return c;
  endfunction

  // driver: one instruction per cycle, expected item pushed alongside
  task automatic drive(input logic [31:0] ins, input ctl_t exp, input string tag);
    @(posedge clk);
    #1;
    instr = ins;
    expQ.push_back(exp);
    tagQ.push_back(tag);
    insQ.push_back(ins);
  endtask

  // monitor: compares mid-cycle, away from the rising edge
  always @(negedge clk) begin
    if (expQ.size() > 0) begin
      ctl_t exp, act;
      string tag;
      logic [31:0] ins;
      exp = expQ.pop_front();
      tag = tagQ.pop_front();
      ins = insQ.pop_front();
      act = {aluOp, aSel, bSel, extSigned, regWrite, dstSel, wbSel, memWrite, pcSel};
      nRun++;
      if (act !== exp) begin
        nFail++;
        $display("FAIL %s instr=%h actual=%h expected=%h", tag, ins, act, exp);
      end
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    // all-zero word first: shift with rd zero, no write (R11, R2)
    drive(32'h0, mk(10, 1, 0, 0, 0, 0, 0, 0, 0), "R11 zero word");

    // R1 register arithmetic and logic
    for (int k = 0; k < 8; k++)
      drive(rIns(3, 4, 5, 0, 32 + k), mk(k, 0, 0, 0, 1, 0, 0, 0, 0), "R1 reg alu");

    // R2 shifts by immediate, R3 variable shifts
    drive(rIns(9, 4, 5, 7, 6'h00), mk(10, 1, 0, 0, 1, 0, 0, 0, 0), "R2 sll");
    drive(rIns(9, 4, 5, 7, 6'h02), mk(11, 1, 0, 0, 1, 0, 0, 0, 0), "R2 srl");
    drive(rIns(9, 4, 5, 7, 6'h03), mk(12, 1, 0, 0, 1, 0, 0, 0, 0), "R2 sra");
    drive(rIns(9, 4, 5, 0, 6'h04), mk(10, 2, 0, 0, 1, 0, 0, 0, 0), "R3 sllv");
    drive(rIns(9, 4, 5, 0, 6'h06), mk(11, 2, 0, 0, 1, 0, 0, 0, 0), "R3 srlv");
    drive(rIns(9, 4, 5, 0, 6'h07), mk(12, 2, 0, 0, 1, 0, 0, 0, 0), "R3 srav");

    // R4 compares
    drive(rIns(1, 2, 3, 0, 6'h2A), mk(8, 0, 0, 0, 1, 0, 2, 0, 0), "R4 slt");
    drive(rIns(1, 2, 3, 0, 6'h2B), mk(9, 0, 0, 0, 1, 0, 2, 0, 0), "R4 sltu");
    drive(iIns(6'h0A, 1, 7, 16'h8000), mk(8, 0, 1, 1, 1, 1, 2, 0, 0), "R4 slti");
    drive(iIns(6'h0B, 1, 7, 16'hFFFF), mk(9, 0, 1, 1, 1, 1, 2, 0, 0), "R4 sltiu");

    // R5 immediate forms and extension mode
    drive(iIns(6'h08, 2, 7, 16'h1234), mk(0, 0, 1, 1, 1, 1, 0, 0, 0), "R5 addi");
    drive(iIns(6'h09, 2, 7, 16'h1234), mk(1, 0, 1, 1, 1, 1, 0, 0, 0), "R5 addiu");
    drive(iIns(6'h0C, 2, 7, 16'hF0F0), mk(4, 0, 1, 0, 1, 1, 0, 0, 0), "R5 andi");
    drive(iIns(6'h0D, 2, 7, 16'hF0F0), mk(5, 0, 1, 0, 1, 1, 0, 0, 0), "R5 ori");
    drive(iIns(6'h0E, 2, 7, 16'hF0F0), mk(6, 0, 1, 0, 1, 1, 0, 0, 0), "R5 xori");

    // R6 load upper
    drive(iIns(6'h0F, 0, 7, 16'hABCD), mk(13, 0, 1, 0, 1, 1, 0, 0, 0), "R6 lui");

    // R7 load, R8 store
    drive(iIns(6'h23, 4, 8, 16'hFFFC), mk(1, 0, 1, 1, 1, 1, 1, 0, 0), "R7 lw");
    drive(iIns(6'h2B, 4, 8, 16'h0010), mk(1, 0, 1, 1, 0, 0, 0, 1, 0), "R8 sw");
    drive(iIns(6'h2B, 4, 0, 16'h0010), mk(1, 0, 1, 1, 0, 0, 0, 1, 0), "R8 sw rt zero");

    // R9 branches
    drive(iIns(6'h04, 4, 5, 16'hFFFE), mk(3, 0, 0, 1, 0, 0, 0, 0, 1), "R9 beq");
    drive(iIns(6'h05, 4, 5, 16'h0003), mk(3, 0, 0, 1, 0, 0, 0, 0, 2), "R9 bne");

    // R10 jumps
    drive({6'h02, 26'h1234567}, mk(0, 0, 0, 0, 0, 0, 0, 0, 3), "R10 j");
    drive({6'h03, 26'h0000040}, mk(0, 0, 0, 0, 1, 2, 3, 0, 3), "R10 jal");
    drive(rIns(31, 0, 0, 0, 6'h08), mk(0, 0, 0, 0, 0, 0, 0, 0, 4), "R10 jr");

    // R11 zero destinations
    drive(rIns(3, 4, 0, 0, 6'h20), mk(0, 0, 0, 0, 0, 0, 0, 0, 0), "R11 add rd0");
    drive(rIns(3, 4, 0, 0, 6'h2A), mk(8, 0, 0, 0, 0, 0, 2, 0, 0), "R11 slt rd0");
    drive(rIns(3, 0, 9, 0, 6'h21), mk(1, 0, 0, 0, 1, 0, 0, 0, 0), "R11 rt0 ignored for rd");
    drive(iIns(6'h08, 3, 0, 16'h0001), mk(0, 0, 1, 1, 0, 1, 0, 0, 0), "R11 addi rt0");
    drive(iIns(6'h23, 3, 0, 16'h0004), mk(1, 0, 1, 1, 0, 1, 1, 0, 0), "R11 lw rt0");
    drive(iIns(6'h08, 3, 9, 16'h0001) & 32'hFFFF_07FF, mk(0, 0, 1, 1, 1, 1, 0, 0, 0), "R11 rd0 ignored for rt");

    // R12 unlisted codes
    drive(iIns(6'h3F, 1, 2, 16'h1234), '0, "R12 bad opcode");
    drive(iIns(6'h20, 1, 2, 16'h1234), '0, "R12 byte load unlisted");
    drive(rIns(1, 2, 3, 0, 6'h01), '0, "R12 bad funct");
    drive(rIns(1, 2, 3, 0, 6'h3F), '0, "R12 bad funct high");

    // random mix of listed opcodes with arbitrary other bits
    for (int n = 0; n < 400; n++) begin
      logic [5:0] opList [16] = '{6'h00, 6'h00, 6'h02, 6'h03, 6'h04, 6'h05, 6'h08, 6'h09,
                                  6'h0A, 6'h0B, 6'h0C, 6'h0D, 6'h0E, 6'h0F, 6'h23, 6'h2B};
      logic [31:0] w;
      w = $urandom;
      if (n % 5 != 4) w[31:26] = opList[$urandom % 16];
      drive(w, model(w), "mix R1 R12");
    end

    @(posedge clk);
    @(negedge clk);
    #1;
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule